// File: doc/BRIEF.md
# Processor Control-Pin Interrupt Controller

This block sits between a processor core and its external control pins. It samples seven pins: time-base enable, external interrupt, system management interrupt, machine check, checkstop, hard reset and soft reset. From them it keeps a pending-interrupt mask, a single hard-interrupt request line, a time-base run/freeze output, a CPU-halt output and a one-cycle system-reset request. Each pin has its own sensitivity: active-high level, active-low level, or falling edge. The block acts only when a pin's synchronized level differs from the level it last stored, so a pin held at a constant level never produces a second event.

Pins pass through a synchronizer of `SYNC_STAGES` flops. The change detector compares the synchronizer output with the stored level and updates the pending mask and the two state machines together. With the default of two stages, a level driven before rising edge 1 is acted on at rising edge 3. The core clears one pending bit with a single-cycle acknowledge that carries the bit index. Pins above the seven defined positions of `pins_i` are ignored.

The block has two state machines. The time-base machine has the states TB_FROZEN and TB_TICKING. The transition TB_FROZEN to TB_TICKING happens on a time-base-enable rise, and TB_TICKING to TB_FROZEN on its fall. The core machine has the states CORE_RUN and CORE_STOPPED. The transition CORE_RUN to CORE_STOPPED happens on a checkstop fall. CORE_STOPPED has no exit other than reset.

Top module: `cpu_pin_ctrl`

## Requirements
- R1: Each defined pin is acted on only when its synchronized level differs from its stored level; the stored level is then updated. A level driven before rising edge 1 is acted on at rising edge 3 (default two-stage synchronizer). A constant or repeated level changes no output.
- R2: Time-base enable (pins_i bit 0, active high): a rise puts tb_run_o high, a fall puts it low.
- R3: External interrupt (bit 1) drives pending bit 0, and system management interrupt (bit 2) drives pending bit 1. Each bit is set on its pin's rise and cleared on its pin's fall.
- R4: Machine check (bit 3) sets pending bit 2 on a 1-to-0 transition. A 0-to-1 transition leaves it unchanged.
- R5: Checkstop (bit 4, active low): a fall puts cpu_halt_o high, and it stays high, whatever the pins do, until rst_n is asserted.
- R6: Hard reset (bit 5, active low): a fall produces exactly one cycle of sys_rst_req_o. A rise produces none.
- R7: Soft reset (bit 6, active high) drives pending bit 3. The bit is set on the pin's rise and cleared on its fall.
- R8: hard_irq_o is high exactly when the pending mask is nonzero.
- R9: pins_i bits at index 7 and above have no effect on any output.
- R10: ack_valid_i with ack_idx_i = n clears pending bit n on the next edge. If a set of bit n is due at the same edge, the acknowledge wins.
- R11: After reset, the pending mask is zero, hard_irq_o is low, tb_run_o is low, cpu_halt_o is low and sys_rst_req_o is low. The stored levels are the idle pattern: bits 3, 4 and 5 high, the others low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | PIN_W | Raw control pins; bits 0..6 defined, the rest ignored |
| ack_valid_i | input | 1 | Single-cycle acknowledge strobe |
| ack_idx_i | input | 2 | Pending bit to clear when ack_valid_i is high |
| pend_o | output | 4 | Pending mask: 0 external, 1 sys-mgmt, 2 machine check, 3 soft reset |
| hard_irq_o | output | 1 | High while any pending bit is set |
| tb_run_o | output | 1 | Time base running (1) or frozen (0) |
| cpu_halt_o | output | 1 | CPU halted by checkstop |
| sys_rst_req_o | output | 1 | One-cycle system-reset request |

## Verification
The assertions treat ack_idx_i as meaningful only in cycles where ack_valid_i is high. They assume that every pending bit change comes from a synchronized pin change or an acknowledge, which makes the no-change stability property a statement about inputs alone. The stimulus holds each random pin pattern for several cycles, so the synchronizer always settles. Acknowledges are issued only while the pins are quiet, except in one directed case that lines the acknowledge up with the set edge of the same bit. Pins are returned to their idle pattern while reset is applied.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

    // defined pin positions on pins_i
    localparam int PIN_TBEN    = 0;
    localparam int PIN_EXT     = 1;
    localparam int PIN_SMI     = 2;
    localparam int PIN_MCHK    = 3;
    localparam int PIN_CKSTP_N = 4;
    localparam int PIN_HRST_N  = 5;
    localparam int PIN_SRST    = 6;
    localparam int NUM_DEF     = 7;

    // idle level of each defined pin (active-low and edge pins rest high)
    localparam logic [NUM_DEF-1:0] DEF_IDLE = 7'b011_1000;

    // pending mask bit positions
    localparam int PND_EXT  = 0;
    localparam int PND_SMI  = 1;
    localparam int PND_MCHK = 2;
    localparam int PND_SRST = 3;
    localparam int PND_W    = 4;

    typedef enum logic {
        TB_FROZEN,
        TB_TICKING
    } tb_state_e;

    typedef enum logic {
        CORE_RUN,
        CORE_STOPPED
    } core_state_e;

    typedef struct packed {
        logic tb_rise;
        logic tb_fall;
        logic ext_rise;
        logic ext_fall;
        logic smi_rise;
        logic smi_fall;
        logic mchk_fall;
        logic ckstp_fall;
        logic hrst_fall;
        logic srst_rise;
        logic srst_fall;
    } pin_evt_t;

endpackage

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
    parameter int           W       = 7,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pinctl_detect.sv
module pinctl_detect
    import pinctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DEF-1:0] lvl_i,
    output pin_evt_t           evt_o,
    output logic               any_chg_o
);

    logic [NUM_DEF-1:0] last_q;
    logic [NUM_DEF-1:0] chg;

    for (genvar p = 0; p < NUM_DEF; p++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        last_q[p] <= DEF_IDLE[p];
            else if (chg[p])   last_q[p] <= lvl_i[p];
        end
        assign chg[p] = lvl_i[p] ^ last_q[p];
    end

    always_comb begin
        evt_o.tb_rise    = chg[PIN_TBEN]    &  lvl_i[PIN_TBEN];
        evt_o.tb_fall    = chg[PIN_TBEN]    & ~lvl_i[PIN_TBEN];
        evt_o.ext_rise   = chg[PIN_EXT]     &  lvl_i[PIN_EXT];
        evt_o.ext_fall   = chg[PIN_EXT]     & ~lvl_i[PIN_EXT];
        evt_o.smi_rise   = chg[PIN_SMI]     &  lvl_i[PIN_SMI];
        evt_o.smi_fall   = chg[PIN_SMI]     & ~lvl_i[PIN_SMI];
        evt_o.mchk_fall  = chg[PIN_MCHK]    & ~lvl_i[PIN_MCHK];
        evt_o.ckstp_fall = chg[PIN_CKSTP_N] & ~lvl_i[PIN_CKSTP_N];
        evt_o.hrst_fall  = chg[PIN_HRST_N]  & ~lvl_i[PIN_HRST_N];
        evt_o.srst_rise  = chg[PIN_SRST]    &  lvl_i[PIN_SRST];
        evt_o.srst_fall  = chg[PIN_SRST]    & ~lvl_i[PIN_SRST];
    end

    assign any_chg_o = |chg;

    // a stored level only moves when the synchronized level differed
    assert_store_on_change_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (chg == '0) |=> $stable(last_q));

endmodule

// File: rtl/pinctl_pending.sv
module pinctl_pending
    import pinctl_pkg::*;
#(
    parameter int ACK_W = $clog2(PND_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_rise_i,
    input  logic             ext_fall_i,
    input  logic             smi_rise_i,
    input  logic             smi_fall_i,
    input  logic             mchk_fall_i,
    input  logic             srst_rise_i,
    input  logic             srst_fall_i,
    input  logic             ack_valid_i,
    input  logic [ACK_W-1:0] ack_idx_i,
    output logic [PND_W-1:0] pend_o,
    output logic             hirq_o
);

    logic [PND_W-1:0] pend_q, pend_d;
    logic [PND_W-1:0] set_v, clr_v, ack_v;
    logic             hirq_q;

    always_comb begin
        set_v           = '0;
        clr_v           = '0;
        set_v[PND_EXT]  = ext_rise_i;
        clr_v[PND_EXT]  = ext_fall_i;
        set_v[PND_SMI]  = smi_rise_i;
        clr_v[PND_SMI]  = smi_fall_i;
        set_v[PND_MCHK] = mchk_fall_i;
        set_v[PND_SRST] = srst_rise_i;
        clr_v[PND_SRST] = srst_fall_i;
        ack_v           = ack_valid_i ? (PND_W'(1) << ack_idx_i) : '0;
        pend_d          = (pend_q | set_v) & ~clr_v & ~ack_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            hirq_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
            hirq_q <= |pend_d;
        end
    end

    assign pend_o = pend_q;
    assign hirq_o = hirq_q;

    assert_mchk_fall_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mchk_fall_i && !(ack_valid_i && ack_idx_i == ACK_W'(PND_MCHK)))
        |=> pend_q[PND_MCHK]);

    assert_ext_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_fall_i) |=> !pend_q[PND_EXT]);

    assert_ack_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_i && ack_idx_i == ACK_W'(PND_EXT)) |=> !pend_q[PND_EXT]);

    assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q != '0) |-> hirq_q);

    assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) |-> !hirq_q);

endmodule

// File: rtl/pinctl_core_fsm.sv
module pinctl_core_fsm
    import pinctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tb_rise_i,
    input  logic tb_fall_i,
    input  logic ckstp_fall_i,
    input  logic hrst_fall_i,
    output logic tb_run_o,
    output logic halt_o,
    output logic rst_req_o
);

    tb_state_e   tb_q,   tb_d;
    core_state_e core_q, core_d;
    logic        rst_req_q;

    // next-state logic
    always_comb begin
        tb_d = tb_q;
        unique case (tb_q)
            TB_FROZEN:  if (tb_rise_i) tb_d = TB_TICKING;
            TB_TICKING: if (tb_fall_i) tb_d = TB_FROZEN;
            default:    tb_d = TB_FROZEN;
        endcase

        core_d = core_q;
        unique case (core_q)
            CORE_RUN:     if (ckstp_fall_i) core_d = CORE_STOPPED;
            CORE_STOPPED: core_d = CORE_STOPPED;
            default:      core_d = CORE_RUN;
        endcase
    end

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_q      <= TB_FROZEN;
            core_q    <= CORE_RUN;
            rst_req_q <= 1'b0;
        end else begin
            tb_q      <= tb_d;
            core_q    <= core_d;
            rst_req_q <= hrst_fall_i;
        end
    end

    // outputs
    always_comb begin
        tb_run_o  = (tb_q == TB_TICKING);
        halt_o    = (core_q == CORE_STOPPED);
        rst_req_o = rst_req_q;
    end

    assert_tb_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tb_rise_i |=> tb_run_o);

    assert_tb_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tb_fall_i |=> !tb_run_o);

    assert_halt_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o);

    assert_rst_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

endmodule

// File: rtl/cpu_pin_ctrl.sv
module cpu_pin_ctrl
    import pinctl_pkg::*;
#(
    parameter int PIN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [PIN_W-1:0]           pins_i,
    input  logic                       ack_valid_i,
    input  logic [$clog2(PND_W)-1:0]   ack_idx_i,
    output logic [PND_W-1:0]           pend_o,
    output logic                       hard_irq_o,
    output logic                       tb_run_o,
    output logic                       cpu_halt_o,
    output logic                       sys_rst_req_o
);

    localparam int ACK_W = $clog2(PND_W);

    logic [NUM_DEF-1:0] lvl_sync;
    pin_evt_t           evt;
    logic               any_chg;

    // pins beyond the defined set are dropped here
    if (PIN_W > NUM_DEF) begin : g_extra
        logic unused_extra_pins;
        assign unused_extra_pins = ^pins_i[PIN_W-1:NUM_DEF];
    end

    pinctl_sync #(
        .W       (NUM_DEF),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (DEF_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_i[NUM_DEF-1:0]),
        .q_o   (lvl_sync)
    );

    pinctl_detect u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (lvl_sync),
        .evt_o     (evt),
        .any_chg_o (any_chg)
    );

    pinctl_pending #(
        .ACK_W (ACK_W)
    ) u_pending (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_rise_i  (evt.ext_rise),
        .ext_fall_i  (evt.ext_fall),
        .smi_rise_i  (evt.smi_rise),
        .smi_fall_i  (evt.smi_fall),
        .mchk_fall_i (evt.mchk_fall),
        .srst_rise_i (evt.srst_rise),
        .srst_fall_i (evt.srst_fall),
        .ack_valid_i (ack_valid_i),
        .ack_idx_i   (ack_idx_i),
        .pend_o      (pend_o),
        .hirq_o      (hard_irq_o)
    );

    pinctl_core_fsm u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .tb_rise_i    (evt.tb_rise),
        .tb_fall_i    (evt.tb_fall),
        .ckstp_fall_i (evt.ckstp_fall),
        .hrst_fall_i  (evt.hrst_fall),
        .tb_run_o     (tb_run_o),
        .halt_o       (cpu_halt_o),
        .rst_req_o    (sys_rst_req_o)
    );

    assert_quiet_no_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_chg && !ack_valid_i) |=>
            ($stable(pend_o) && $stable(tb_run_o) && $stable(cpu_halt_o) && !sys_rst_req_o));

endmodule

// File: tb/sim_cpu_pin_ctrl.sv
module sim_cpu_pin_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int PIN_W      = 8;
    localparam logic [PIN_W-1:0] IDLE = 8'b0011_1000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PIN_W-1:0] pins = IDLE;
    logic             ack_valid = 1'b0;
    logic [1:0]       ack_idx = 2'd0;
    logic [3:0]       pend;
    logic             hirq, tb_run, halt, rst_req;

    int total = 0;
    int bad   = 0;

    // bench model, built from the requirements
    logic [6:0] m_lvl;
    logic [3:0] m_pend;
    logic       m_tb, m_halt;
    int         m_pulses;
    int         seen_pulses;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_pin_ctrl #(.PIN_W(PIN_W), .SYNC_STAGES(2)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .pins_i        (pins),
        .ack_valid_i   (ack_valid),
        .ack_idx_i     (ack_idx),
        .pend_o        (pend),
        .hard_irq_o    (hirq),
        .tb_run_o      (tb_run),
        .cpu_halt_o    (halt),
        .sys_rst_req_o (rst_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " R3/R4/R7/R10 pend"}, int'(pend), int'(m_pend));
        chk({tag, " R8 irq"}, int'(hirq), int'(m_pend != 4'd0));
        chk({tag, " R2 tb_run"}, int'(tb_run), int'(m_tb));
        chk({tag, " R5 halt"}, int'(halt), int'(m_halt));
    endtask

    function automatic void model_pins(input logic [PIN_W-1:0] v);
        for (int i = 0; i < 7; i++) begin
            if (v[i] != m_lvl[i]) begin
                case (i)
                    0: m_tb = v[i];
                    1: m_pend[0] = v[i];
                    2: m_pend[1] = v[i];
                    3: if (!v[i]) m_pend[2] = 1'b1;
                    4: if (!v[i]) m_halt = 1'b1;
                    5: if (!v[i]) m_pulses = 1;
                    6: m_pend[3] = v[i];
                    default: ;
                endcase
                m_lvl[i] = v[i];
            end
        end
    endfunction

    // drive a pin pattern and wait until it has been acted on
    task automatic apply(input logic [PIN_W-1:0] v);
        m_pulses = 0;
        seen_pulses = 0;
        @(negedge clk);
        pins = v;
        model_pins(v);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (rst_req) seen_pulses++;
        end
    endtask

    task automatic do_ack(input logic [1:0] idx);
        @(negedge clk);
        ack_valid = 1'b1;
        ack_idx   = idx;
        @(negedge clk);
        ack_valid = 1'b0;
        m_pend[idx] = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        pins  = IDLE;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_lvl = IDLE[6:0];
        m_pend = 4'd0;
        m_tb = 1'b0;
        m_halt = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [PIN_W-1:0] cur;
        void'($urandom(32'd20240611));
        m_lvl = IDLE[6:0];
        m_pend = 4'd0;
        m_tb = 1'b0;
        m_halt = 1'b0;
        m_pulses = 0;
        seen_pulses = 0;
        do_reset();

        // R11: reset state
        chk_all("R11 reset");
        chk("R11 rst_req", int'(rst_req), 0);

        // R9: unused pin toggles have no effect
        apply(IDLE | 8'h80);
        chk_all("R9 extra pin high");
        apply(IDLE);
        chk_all("R9 extra pin low");

        // R3 external interrupt, R8
        cur = IDLE | 8'h02;
        apply(cur);
        chk_all("R3 ext rise");
        // R10: ack, then same level repeated gives no new event (R1)
        do_ack(2'd0);
        chk_all("R10 ack ext");
        apply(cur);
        chk_all("R1 repeat level");
        apply(IDLE);
        chk_all("R3 ext fall");

        // R4: machine check, rise does nothing, fall sets
        apply(IDLE & ~8'h08);
        chk_all("R4 mchk fall");
        apply(IDLE);
        chk_all("R4 mchk rise");
        do_ack(2'd2);
        chk_all("R10 ack mchk");

        // R6: hard reset pulse on fall only
        apply(IDLE & ~8'h20);
        chk("R6 fall pulses", seen_pulses, 1);
        apply(IDLE);
        chk("R6 rise pulses", seen_pulses, 0);

        // R2 time base, R7 soft reset
        apply(IDLE | 8'h41);
        chk_all("R2/R7 rise");
        apply(IDLE);
        chk_all("R2/R7 fall");

        // R10: ack collides with the set of the same bit
        @(negedge clk);
        pins = IDLE | 8'h02;
        @(negedge clk);
        @(negedge clk);
        ack_valid = 1'b1;
        ack_idx = 2'd0;
        @(negedge clk);
        ack_valid = 1'b0;
        repeat (2) @(negedge clk);
        m_lvl[1] = 1'b1;
        chk_all("R10 ack beats set");
        apply(IDLE);

        // R5: checkstop halts, release does not restart, reset does
        apply(IDLE & ~8'h10);
        chk_all("R5 ckstp fall");
        apply(IDLE);
        chk_all("R5 ckstp release");
        do_reset();
        chk_all("R5 R11 after reset");

        // constrained random mix
        cur = IDLE;
        for (int it = 0; it < 400; it++) begin
            if (it == 200) begin
                do_reset();
                cur = IDLE;
                chk_all("R11 mid reset");
            end
            if (($urandom % 6) == 0) begin
                do_ack(2'($urandom % 4));
                chk_all("R10 rand ack");
            end else begin
                logic [PIN_W-1:0] flip;
                flip = PIN_W'($urandom) & PIN_W'($urandom);
                cur = cur ^ flip;
                apply(cur);
                chk_all("R1 rand pins");
                chk("R6 rand pulses", seen_pulses, m_pulses);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule